// File: doc/BRIEF.md
# DDR Input Capture with Half-Rate Widening

This block receives one or more double-data-rate data pins together with their strobe. On each lane it samples one bit on each strobe edge and realigns the two bits onto the later edge. It moves the pair into a full-rate clock domain. It then packs two consecutive pairs into a four-bit half-rate word for the core. A divide-by-two counter in the full-rate domain produces the half-rate clock, which is exported with the data.

Each of the three stages can be bypassed under static configuration: capture, resynchronization and widening. The strobe can be inverted before capture, as DDR-family memories require. A run-time select routes either the half-rate word or a direct input word to the output. The select is taken only on half-rate edges, so the output switches cleanly.

Top module: `ddrin_path`

## Requirements
- R1: With capture active, each lane forms a pair from the bit sampled on the effective strobe rising edge (pair bit 0, "earlier") and the bit sampled on the following falling edge (pair bit 1, "later"). Both bits are presented together after that falling edge.
- R2: When `cfg_strobe_inv` is 1, the strobe is inverted before it clocks the capture registers, so the physical falling edge captures the earlier bit.
- R3: With resynchronization active, the pair reaches the widening stage one full-rate cycle later than with `cfg_rsync_bypass` = 1.
- R4: With widening active, `data_o` for lane l updates on every second full-rate edge, starting with the second edge after reset release. Bits 4l+0 and 4l+1 are the earlier and later bits of the older pair; bits 4l+2 and 4l+3 are those of the newer pair.
- R5: `clk_half_o` is the full-rate clock divided by two. It is high during reset and rises on each edge where a half-rate word is loaded.
- R6: With `cfg_half_bypass` = 1, the word loads on every full-rate edge, and lane l carries the current pair in bits 4l+1:4l and again in bits 4l+3:4l+2.
- R7: With `cfg_cap_bypass` = 1, both bits of a lane's pair follow the pin level directly, with no strobe register.
- R8: `direct_sel` = 1 drives `data_o` from `direct_in` (combinational), and 0 drives it from the word. The select is registered only on word-load edges.
- R9: `rst_n` low at a full-rate edge clears the word and the select, so `data_o` = 0, and it sets the divider phase so that `clk_half_o` = 1. Capture registers clear on strobe edges while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fr | input | 1 | Full-rate resynchronization clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Data strobe from the memory |
| pin | input | LANES | DDR data pins |
| cfg_cap_bypass | input | 1 | Static: skip strobe capture |
| cfg_rsync_bypass | input | 1 | Static: skip full-rate resync registers |
| cfg_half_bypass | input | 1 | Static: skip half-rate widening |
| cfg_strobe_inv | input | 1 | Static: invert strobe before capture |
| direct_sel | input | 1 | Run-time: choose direct word over half-rate word |
| direct_in | input | 4*LANES | Direct data word |
| data_o | output | 4*LANES | Word to the core |
| clk_half_o | output | 1 | Half-rate clock exported with the data |

## Verification
A wrong divider phase after reset shows up as word boundaries shifted by one full-rate cycle: older and newer pairs swap halves within two cycles of reset release. A stuck or extra resync stage moves every word by one full-rate cycle. A capture register on the wrong strobe edge exchanges bits 4l and 4l+1 on the first loaded word. A select register that loads on the wrong edges makes `data_o` switch between words one full-rate cycle early. All of these appear at `data_o` within four full-rate cycles of the faulty event.

// File: rtl/ddrin_pkg.sv
package ddrin_pkg;
   localparam int unsigned PAIR_W = 2;
   localparam int unsigned WORD_W = 4;

   typedef struct packed {
      logic cap_bypass;
      logic rsync_bypass;
      logic half_bypass;
      logic strobe_inv;
   } ddrin_cfg_t;
endpackage

// File: rtl/ddrin_capture.sv
module ddrin_capture
   import ddrin_pkg::*;
#(
   parameter int unsigned LANES = 2
) (
   input  logic                      strobe,
   input  logic                      rst_n,
   input  logic                      strobe_inv,
   input  logic                      bypass,
   input  logic [LANES-1:0]          pin,
   output logic [PAIR_W*LANES-1:0]   pair_o
);
   logic s_eff;
   assign s_eff = strobe ^ strobe_inv;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic rise_q, fall_q, align_q;

      always_ff @(posedge s_eff) begin
         if (!rst_n) rise_q <= 1'b0;
         else        rise_q <= pin[l];
      end

      always_ff @(negedge s_eff) begin
         if (!rst_n) begin
            fall_q  <= 1'b0;
            align_q <= 1'b0;
         end else begin
            fall_q  <= pin[l];
            align_q <= rise_q;
         end
      end

      assign pair_o[PAIR_W*l]   = bypass ? pin[l] : align_q;
      assign pair_o[PAIR_W*l+1] = bypass ? pin[l] : fall_q;
   end
endmodule

// File: rtl/ddrin_resync.sv
module ddrin_resync
   import ddrin_pkg::*;
#(
   parameter int unsigned LANES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bypass,
   input  logic [PAIR_W*LANES-1:0]   pair_i,
   output logic [PAIR_W*LANES-1:0]   pair_o
);
   localparam int unsigned BW = PAIR_W * LANES;
   logic [BW-1:0] sync_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= pair_i;
   end

   assign pair_o = bypass ? pair_i : sync_q;
endmodule

// File: rtl/ddrin_clkdiv.sv
module ddrin_clkdiv (
   input  logic clk,
   input  logic rst_n,
   output logic load_o,
   output logic clk_half_o
);
   logic phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= 1'b0;
      else        phase_q <= ~phase_q;
   end

   assign load_o     = phase_q;
   assign clk_half_o = ~phase_q;

   assert_div_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (clk_half_o != $past(clk_half_o)));

   assert_div_reset_R9: assert property (@(posedge clk)
      !rst_n |=> clk_half_o);
endmodule

// File: rtl/ddrin_halfrate.sv
module ddrin_halfrate
   import ddrin_pkg::*;
#(
   parameter int unsigned LANES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bypass,
   input  logic                      load_i,
   input  logic [PAIR_W*LANES-1:0]   pair_i,
   input  logic                      direct_sel,
   input  logic [WORD_W*LANES-1:0]   direct_in,
   output logic [WORD_W*LANES-1:0]   data_o
);
   localparam int unsigned PW = PAIR_W * LANES;
   localparam int unsigned WW = WORD_W * LANES;

   logic [PW-1:0] older_q;
   logic [WW-1:0] word_q, merge_w, dup_w;
   logic [PW-1:0] word_lo, word_hi;
   logic          sel_q;

   for (genvar l = 0; l < LANES; l++) begin : g_pack
      assign merge_w[WORD_W*l +: WORD_W] = {pair_i[PAIR_W*l +: PAIR_W], older_q[PAIR_W*l +: PAIR_W]};
      assign dup_w[WORD_W*l +: WORD_W]   = {pair_i[PAIR_W*l +: PAIR_W], pair_i[PAIR_W*l +: PAIR_W]};
      assign word_lo[PAIR_W*l +: PAIR_W] = word_q[WORD_W*l +: PAIR_W];
      assign word_hi[PAIR_W*l +: PAIR_W] = word_q[WORD_W*l+PAIR_W +: PAIR_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         older_q <= '0;
         word_q  <= '0;
         sel_q   <= 1'b0;
      end else if (bypass) begin
         word_q  <= dup_w;
         sel_q   <= direct_sel;
      end else if (load_i) begin
         word_q  <= merge_w;
         sel_q   <= direct_sel;
      end else begin
         older_q <= pair_i;
      end
   end

   assign data_o = sel_q ? direct_in : word_q;

   assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && !load_i) |=> $stable(word_q));

   assert_bypass_dup_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |-> (word_lo == word_hi));

   assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && !load_i) |=> $stable(sel_q));

   assert_reset_clear_R9: assert property (@(posedge clk)
      !rst_n |=> (word_q == '0 && !sel_q));
endmodule

// File: rtl/ddrin_path.sv
module ddrin_path
   import ddrin_pkg::*;
#(
   parameter int unsigned LANES = 2
) (
   input  logic                       clk_fr,
   input  logic                       rst_n,
   input  logic                       strobe,
   input  logic [LANES-1:0]           pin,
   input  logic                       cfg_cap_bypass,
   input  logic                       cfg_rsync_bypass,
   input  logic                       cfg_half_bypass,
   input  logic                       cfg_strobe_inv,
   input  logic                       direct_sel,
   input  logic [WORD_W*LANES-1:0]    direct_in,
   output logic [WORD_W*LANES-1:0]    data_o,
   output logic                       clk_half_o
);
   localparam int unsigned PW = PAIR_W * LANES;

   if (LANES < 1) begin : g_bad_lanes
      $error("ddrin_path: LANES must be at least 1");
   end

   ddrin_cfg_t cfg;
   assign cfg = '{cap_bypass: cfg_cap_bypass, rsync_bypass: cfg_rsync_bypass,
                  half_bypass: cfg_half_bypass, strobe_inv: cfg_strobe_inv};

   logic [PW-1:0] cap_pair, rs_pair;
   logic          load;

   ddrin_capture #(.LANES(LANES)) u_cap (
      .strobe     (strobe),
      .rst_n      (rst_n),
      .strobe_inv (cfg.strobe_inv),
      .bypass     (cfg.cap_bypass),
      .pin        (pin),
      .pair_o     (cap_pair)
   );

   ddrin_resync #(.LANES(LANES)) u_rs (
      .clk    (clk_fr),
      .rst_n  (rst_n),
      .bypass (cfg.rsync_bypass),
      .pair_i (cap_pair),
      .pair_o (rs_pair)
   );

   assert_rsync_delay_R3: assert property (@(posedge clk_fr) disable iff (!rst_n)
      !cfg.rsync_bypass |=> (rs_pair == $past(cap_pair)));

   ddrin_clkdiv u_div (
      .clk        (clk_fr),
      .rst_n      (rst_n),
      .load_o     (load),
      .clk_half_o (clk_half_o)
   );

   ddrin_halfrate #(.LANES(LANES)) u_hr (
      .clk        (clk_fr),
      .rst_n      (rst_n),
      .bypass     (cfg.half_bypass),
      .load_i     (load),
      .pair_i     (rs_pair),
      .direct_sel (direct_sel),
      .direct_in  (direct_in),
      .data_o     (data_o)
   );
endmodule

// File: tb/tb_ddrin_path.sv
module tb_ddrin_path;
   localparam int W  = 2;
   localparam int NC = 12;

   // {cap_bypass, rsync_bypass, half_bypass, strobe_inv, seed}
   // R1 R2 R3 R4 R6 R7 R8 exercised across these rows; R5 R9 each cycle/reset
   localparam logic [11:0] VEC [8] = '{
      {4'b0000, 8'hA5}, {4'b0001, 8'h3C}, {4'b0100, 8'h5A}, {4'b0010, 8'hC3},
      {4'b1000, 8'h96}, {4'b1110, 8'h69}, {4'b0101, 8'hF0}, {4'b1010, 8'h1E}};

   logic clk = 1'b0, rst_n = 1'b0, strb_log = 1'b0;
   logic cb = 1'b0, rb = 1'b0, hb = 1'b0, inv = 1'b0;
   logic [W-1:0] pin = '0;
   logic dsel = 1'b0;
   logic [4*W-1:0] dir = '0;
   logic [4*W-1:0] data_o;
   logic clk_half;
   logic strobe;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   assign strobe = strb_log ^ inv;
   always #4 clk = ~clk;

   ddrin_path #(.LANES(W)) dut (
      .clk_fr(clk), .rst_n(rst_n), .strobe(strobe), .pin(pin),
      .cfg_cap_bypass(cb), .cfg_rsync_bypass(rb), .cfg_half_bypass(hb),
      .cfg_strobe_inv(inv), .direct_sel(dsel), .direct_in(dir),
      .data_o(data_o), .clk_half_o(clk_half));

   task automatic chk(input logic [4*W-1:0] act, input logic [4*W-1:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic run_cycle(input logic [W-1:0] ev, input logic [W-1:0] od,
                            input logic ds, input logic [4*W-1:0] dv, input logic rel,
                            input logic [4*W-1:0] exp_d, input logic exp_h, input string tag);
      @(posedge clk);
      #1 pin = ev; dsel = ds; dir = dv;
      if (rel) rst_n = 1'b1;
      #2 strb_log = 1'b1;
      #1 chk(data_o, exp_d, tag);
      chk({{(4*W-1){1'b0}}, clk_half}, {{(4*W-1){1'b0}}, exp_h}, "R5 half clock");
      #1 pin = od;
      #2 strb_log = 1'b0;
   endtask

   initial begin
      #(8 * 50000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R9: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int v = 0; v < 8; v++) begin
         logic [2*W-1:0] src [NC];
         logic [NC-1:0]  dsh;
         logic [2*W-1:0] older, inp;
         logic [4*W-1:0] w;
         logic           sq;
         logic [15:0]    r;
         string          tag;
         {cb, rb, hb, inv} = VEC[v][11:8];
         r = {VEC[v][7:0], ~VEC[v][7:0]};
         rst_n = 1'b0;
         // R9: reset clears the word and sets the half clock high
         for (int i = 0; i < 3; i++) run_cycle('0, '0, 1'b0, '0, 1'b0, '0, 1'b1, "R9 reset");
         older = '0; w = '0; sq = 1'b0;
         tag = {cb ? "R7 " : "R1 ", inv ? "R2 " : "", rb ? "" : "R3 ", hb ? "R6 " : "R4 ", "R8"};
         for (int m = 0; m < NC; m++) begin
            logic [W-1:0]   ev, od;
            logic           ds;
            logic [4*W-1:0] dv, expd;
            int             k;
            for (int s = 0; s < 5; s++) r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            ev = r[1:0]; od = r[3:2]; ds = r[4]; dv = r[12:5];
            for (int l = 0; l < W; l++) begin
               src[m][2*l]   = cb ? od[l] : ev[l];
               src[m][2*l+1] = od[l];
            end
            dsh[m] = ds;
            if (m > 0) begin
               k = m - 1 - (rb ? 0 : 1);
               inp = (k >= 0) ? src[k] : '0;
               if (hb) begin
                  for (int l = 0; l < W; l++) w[4*l +: 4] = {inp[2*l +: 2], inp[2*l +: 2]};
                  sq = dsh[m-1];
               end else if (m % 2 == 1) begin
                  older = inp;
               end else begin
                  for (int l = 0; l < W; l++) w[4*l +: 4] = {inp[2*l +: 2], older[2*l +: 2]};
                  sq = dsh[m-1];
               end
            end
            expd = sq ? dv : w;
            run_cycle(ev, od, ds, dv, (m == 0), expd,
                      (m == 0) ? 1'b1 : (m % 2 == 0), (m == 0) ? "R9 release" : tag);
         end
      end
      // directed: reset applied mid-stream clears output (R9)
      @(posedge clk); #1 rst_n = 1'b0; dsel = 1'b0;
      run_cycle('1, '1, 1'b0, '1, 1'b0, '0, 1'b1, "R9 mid-stream reset");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule